// File: doc/BRIEF.md
# USB bulk OUT endpoint status controller

This block keeps the control and status state of one bulk OUT endpoint in a USB device controller. It also chooses the handshake that the endpoint gives to the next OUT token. The serial interface engine reports the end of each packet, together with any CRC, bit-stuffing or overrun errors that came with it. The engine separately reports a packet that ran past the maximum size. The block latches these events into sticky bits that the CPU reads and clears by writing ones. From those bits the block derives the ACK/NAK/STALL choice, a receive interrupt, and a DMA service request taken from the receive FIFO fill level.

The CPU can force the endpoint into a stall. The stall state is entered only when the bus is idle, so a transfer already in flight finishes undisturbed. Entering the stall state marks the sent-stall bit. The endpoint leaves the stall state only after the CPU has cleared both the force bit and the sent-stall bit. While a completed packet waits for the CPU, further packets are refused with NAK. The FIFO not-empty flag tells the CPU whether bytes are still left to drain.

Top module: `usb_oep_ctrl`

## Requirements
- R1: A packet-done pulse, when no oversize pulse comes with it, sets the complete flag (status bit 0) unless the endpoint is stalled. Writing 1 to bit 0 clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R2: While the complete flag is set and the endpoint is not stalled, the handshake output is NAK. Handshake codes are ACK=0, NAK=1, STALL=2.
- R3: The receive interrupt is high exactly when the complete flag is set and the interrupt-enable input is high.
- R4: The error flag (status bit 1) latches the OR of the CRC, bit-stuff and overrun inputs at packet done. It clears whenever the complete flag clears.
- R5: An oversize pulse puts the endpoint into the stall state and sets the sent-stall flag (status bit 2) on the next cycle.
- R6: A write sets or clears the force bit (status bit 3) directly from bit 3 of the write data. A set force bit starts the stall state, and sets sent-stall, only on an edge where the bus is idle.
- R7: The stall state holds while force or sent-stall is set. It ends on the edge after both are seen clear. Writing 1 to bit 2 clears sent-stall.
- R8: Handshake priority is STALL, then NAK, then ACK. While stalled, the handshake is STALL even when the complete flag is set.
- R9: The service/DMA request (status bit 4) is high when the FIFO byte count is 8 or more. Not-empty (status bit 5) is high when the count is nonzero. The FIFO holds 20 bytes.
- R10: Reset clears all state. Zero bits in a write leave complete, error and sent-stall unchanged.
- R11: A packet-done pulse during the stall state does not change the complete flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_done | input | 1 | Packet received pulse |
| err_crc | input | 1 | CRC error, valid with pkt_done |
| err_stuff | input | 1 | Bit-stuff error, valid with pkt_done |
| err_ovr | input | 1 | FIFO overrun, valid with pkt_done |
| pkt_oversize | input | 1 | Host sent more than the maximum packet size |
| bus_active | input | 1 | A transfer is in progress on the bus |
| fifo_count | input | 5 | Bytes held in the receive FIFO |
| rx_irq_en | input | 1 | Receive interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: bit0 and bit2 clear on one, bit3 is the force value |
| reg_rdata | output | 6 | Status bits |
| hs_sel | output | 2 | Handshake for the next OUT token |
| rx_irq | output | 1 | Receive interrupt |
| dma_req | output | 1 | FIFO service request |

## Verification
The cases that are hardest to reach from the ports are the exit conditions of the stall state. The force bit and the sent-stall bit must be cleared in both orders. Each order must also be observed across the one-cycle lag, during which STALL persists after the last bit has cleared. The stimulus first holds the bus active while force is written, to show that entry is deferred. It then drops the bus to idle and clears force and sent-stall in each order, sampling the handshake on every cycle. Same-cycle collisions are also driven: a set and a clear of the complete flag together, and an oversize pulse while a packet is pending.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;
    localparam int B_CMP  = 0;
    localparam int B_ERR  = 1;
    localparam int B_SNT  = 2;
    localparam int B_FRC  = 3;
    localparam int B_SVC  = 4;
    localparam int B_NE   = 5;
    localparam int STAT_W = 6;
    localparam int WR_W   = 4;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    typedef struct packed {
        logic complete;
        logic err;
        logic sent;
        logic frc;
        logic stall;
    } ep_state_t;
endpackage

// File: rtl/usb_oep_status.sv
module usb_oep_status
    import usb_oep_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pkt_done,
    input  logic            err_any,
    input  logic            pkt_oversize,
    input  logic            bus_active,
    input  logic            reg_wr,
    input  logic [WR_W-1:0] reg_wdata,
    output ep_state_t       st
);
    ep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) st_d.frc = reg_wdata[B_FRC];
        if (reg_wr && reg_wdata[B_CMP]) begin
            st_d.complete = 1'b0;
            st_d.err      = 1'b0;
        end
        if (reg_wr && reg_wdata[B_SNT]) st_d.sent = 1'b0;
        // leave stall only once both holders are seen clear
        if (st_q.stall && !st_q.frc && !st_q.sent) st_d.stall = 1'b0;
        // deferred entry of a forced stall
        if (!st_q.stall && st_q.frc && !bus_active) begin
            st_d.stall = 1'b1;
            st_d.sent  = 1'b1;
        end
        if (pkt_oversize) begin
            st_d.stall = 1'b1;
            st_d.sent  = 1'b1;
        end
        if (pkt_done && !st_q.stall && !pkt_oversize) begin
            st_d.complete = 1'b1;
            st_d.err      = err_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R4: error is only ever seen together with complete
    a_r4_err_with_complete: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> st_q.complete);

    // R1: complete drops only after a write of one to its bit
    a_r1_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.complete) |-> $past(reg_wr && reg_wdata[B_CMP]));

    // R5: oversize leads to stall with sent-stall marked
    a_r5_oversize_stall: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_oversize |=> (st_q.stall && st_q.sent));

    // R6: stall is entered only through oversize or idle-bus forced entry
    a_r6_entry_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stall) |-> ($past(pkt_oversize) ||
                               ($past(st_q.frc) && !$past(bus_active))));

    // R6: entering stall always marks sent-stall
    a_r6_entry_marks_sent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stall) |-> st_q.sent);

    // R7: stall holds while force or sent-stall remains
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stall && (st_q.frc || st_q.sent)) |=> st_q.stall);

    // R11: packet done during stall leaves complete alone
    a_r11_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && st_q.stall && !(reg_wr && reg_wdata[B_CMP]))
            |=> (st_q.complete == $past(st_q.complete)));
endmodule

// File: rtl/usb_oep_fifo_mon.sv
module usb_oep_fifo_mon #(
    parameter int DEPTH  = 20,
    parameter int THRESH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] fifo_count,
    output logic             svc_req,
    output logic             not_empty
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    always_comb begin
        svc_req   = (fifo_count >= THR);
        not_empty = (fifo_count != '0);
    end

    // R9: a service request implies bytes are present
    always_comb begin
        a_r9_svc_nonempty: assert (!svc_req || not_empty);
    end
endmodule

// File: rtl/usb_oep_handshake.sv
module usb_oep_handshake
    import usb_oep_pkg::*;
(
    input  ep_state_t st,
    input  logic      rx_irq_en,
    output hs_e       hs,
    output logic      rx_irq
);
    always_comb begin
        if (st.stall)         hs = HS_STALL;
        else if (st.complete) hs = HS_NAK;
        else                  hs = HS_ACK;
        rx_irq = st.complete && rx_irq_en;
    end

    // R8: ACK is never given while a packet is pending
    always_comb begin
        a_r8_no_ack_pending: assert (!(st.complete && hs == HS_ACK));
    end
endmodule

// File: rtl/usb_oep_ctrl.sv
module usb_oep_ctrl
    import usb_oep_pkg::*;
#(
    parameter int FIFO_DEPTH = 20,
    parameter int SVC_THRESH = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic              err_crc,
    input  logic              err_stuff,
    input  logic              err_ovr,
    input  logic              pkt_oversize,
    input  logic              bus_active,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              rx_irq_en,
    input  logic              reg_wr,
    input  logic [WR_W-1:0]   reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [1:0]        hs_sel,
    output logic              rx_irq,
    output logic              dma_req
);
    ep_state_t st;
    hs_e       hs;
    logic      svc, nempty;

    usb_oep_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_done     (pkt_done),
        .err_any      (err_crc | err_stuff | err_ovr),
        .pkt_oversize (pkt_oversize),
        .bus_active   (bus_active),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .st           (st)
    );

    usb_oep_fifo_mon #(.DEPTH(FIFO_DEPTH), .THRESH(SVC_THRESH)) u_fifo (
        .fifo_count (fifo_count),
        .svc_req    (svc),
        .not_empty  (nempty)
    );

    usb_oep_handshake u_hs (
        .st        (st),
        .rx_irq_en (rx_irq_en),
        .hs        (hs),
        .rx_irq    (rx_irq)
    );

    always_comb begin
        reg_rdata        = '0;
        reg_rdata[B_CMP] = st.complete;
        reg_rdata[B_ERR] = st.err;
        reg_rdata[B_SNT] = st.sent;
        reg_rdata[B_FRC] = st.frc;
        reg_rdata[B_SVC] = svc;
        reg_rdata[B_NE]  = nempty;
        hs_sel           = hs;
        dma_req          = svc;
    end
endmodule

// File: tb/usb_oep_ctrl_bench.sv
module usb_oep_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] ACK = 2'd0, NAK = 2'd1, STL = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_done = 0, err_crc = 0, err_stuff = 0, err_ovr = 0;
    logic pkt_oversize = 0, bus_active = 0, rx_irq_en = 0, reg_wr = 0;
    logic [4:0] fifo_count = '0;
    logic [3:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic [1:0] hs_sel;
    logic rx_irq, dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_oep_ctrl u_usb_oep_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .err_crc(err_crc),
        .err_stuff(err_stuff), .err_ovr(err_ovr), .pkt_oversize(pkt_oversize),
        .bus_active(bus_active), .fifo_count(fifo_count), .rx_irq_en(rx_irq_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hs_sel(hs_sel), .rx_irq(rx_irq), .dma_req(dma_req)
    );

    typedef struct packed {
        logic       done, crc, stf, ovr, osz, busy, wr;
        logic [3:0] wd;
        logic       ien;
        logic [4:0] cnt;
        logic [5:0] e_rd;
        logic [1:0] e_hs;
        logic       e_irq, e_dma;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    // done crc stf ovr osz busy wr wd ien cnt | rd hs irq dma | req
    localparam vec_t VEC [NV] = '{
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h00,ACK,0,0, 4'd10}, // R10 idle
        '{0,0,0,0,0,0,0,4'h0,0, 5'd3,  6'h20,ACK,0,0, 4'd9},  // R9 not empty
        '{1,0,0,0,0,0,0,4'h0,1, 5'd3,  6'h21,NAK,1,0, 4'd1},  // R1 R2 R3
        '{0,0,0,0,0,0,0,4'h0,1, 5'd8,  6'h31,NAK,1,1, 4'd9},  // R9 threshold
        '{0,0,0,0,0,0,1,4'h0,1, 5'd7,  6'h21,NAK,1,0, 4'd10}, // R10 zero write
        '{0,0,0,0,0,0,1,4'h1,1, 5'd0,  6'h00,ACK,0,0, 4'd1},  // R1 clear
        '{1,1,0,0,0,0,0,4'h0,0, 5'd12, 6'h33,NAK,0,1, 4'd4},  // R4 crc, R3 off
        '{0,0,0,0,0,0,1,4'h1,0, 5'd0,  6'h00,ACK,0,0, 4'd4},
        '{1,0,1,0,0,0,0,4'h0,0, 5'd0,  6'h03,NAK,0,0, 4'd4},  // R4 stuff
        '{0,0,0,0,0,0,1,4'h1,0, 5'd0,  6'h00,ACK,0,0, 4'd4},
        '{1,0,0,1,0,0,0,4'h0,0, 5'd0,  6'h03,NAK,0,0, 4'd4},  // R4 overrun
        '{0,0,0,0,0,0,1,4'h1,0, 5'd0,  6'h00,ACK,0,0, 4'd4},
        '{0,0,0,0,0,1,1,4'h8,0, 5'd0,  6'h08,ACK,0,0, 4'd6},  // R6 force, busy
        '{0,0,0,0,0,1,0,4'h0,0, 5'd0,  6'h08,ACK,0,0, 4'd6},  // R6 deferred
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h0C,STL,0,0, 4'd6},  // R6 entry idle
        '{0,0,0,0,0,0,1,4'hC,0, 5'd0,  6'h08,STL,0,0, 4'd7},  // R7 sent clr first
        '{0,0,0,0,0,0,1,4'h0,0, 5'd0,  6'h00,STL,0,0, 4'd7},  // R7 lag
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h00,ACK,0,0, 4'd7},  // R7 exit
        '{0,0,0,0,0,0,1,4'h8,0, 5'd0,  6'h08,ACK,0,0, 4'd6},
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h0C,STL,0,0, 4'd6},
        '{0,0,0,0,0,0,1,4'h0,0, 5'd0,  6'h04,STL,0,0, 4'd7},  // R7 force clr first
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h04,STL,0,0, 4'd7},
        '{0,0,0,0,0,0,1,4'h4,0, 5'd0,  6'h00,STL,0,0, 4'd7},
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h00,ACK,0,0, 4'd7},
        '{0,0,0,0,1,0,0,4'h0,0, 5'd0,  6'h04,STL,0,0, 4'd5},  // R5 oversize
        '{1,0,0,0,0,0,0,4'h0,1, 5'd0,  6'h04,STL,0,0, 4'd11}, // R11 done in stall
        '{0,0,0,0,0,0,1,4'h4,0, 5'd0,  6'h00,STL,0,0, 4'd7},
        '{0,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h00,ACK,0,0, 4'd7},
        '{1,0,0,0,0,0,1,4'h1,0, 5'd0,  6'h01,NAK,0,0, 4'd1},  // R1 set wins
        '{0,0,0,0,0,0,1,4'h1,0, 5'd0,  6'h00,ACK,0,0, 4'd1},
        '{1,0,0,0,0,0,0,4'h0,0, 5'd0,  6'h01,NAK,0,0, 4'd2},  // R2
        '{0,0,0,0,1,0,0,4'h0,0, 5'd0,  6'h05,STL,0,0, 4'd8},  // R8 stall over nak
        '{0,0,0,0,0,0,1,4'h5,0, 5'd0,  6'h00,STL,0,0, 4'd7},
        '{0,0,0,0,0,0,0,4'h0,0, 5'd20, 6'h30,ACK,0,1, 4'd9}   // R9 full
    };

    task automatic check(input string tag, input logic [5:0] e_rd,
                         input logic [1:0] e_hs, input logic e_irq, input logic e_dma);
        n_chk++;
        if (reg_rdata !== e_rd || hs_sel !== e_hs || rx_irq !== e_irq || dma_req !== e_dma) begin
            n_bad++;
            $display("FAIL %s: rd=%h hs=%0d irq=%b dma=%b expected rd=%h hs=%0d irq=%b dma=%b",
                     tag, reg_rdata, hs_sel, rx_irq, dma_req, e_rd, e_hs, e_irq, e_dma);
        end
    endtask

    task automatic idle_inputs();
        pkt_done = 0; err_crc = 0; err_stuff = 0; err_ovr = 0; pkt_oversize = 0;
        bus_active = 0; reg_wr = 0; reg_wdata = '0; rx_irq_en = 0; fifo_count = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset state", 6'h00, ACK, 0, 0);

        for (int i = 0; i < NV; i++) begin
            pkt_done = VEC[i].done; err_crc = VEC[i].crc; err_stuff = VEC[i].stf;
            err_ovr = VEC[i].ovr; pkt_oversize = VEC[i].osz; bus_active = VEC[i].busy;
            reg_wr = VEC[i].wr; reg_wdata = VEC[i].wd; rx_irq_en = VEC[i].ien;
            fifo_count = VEC[i].cnt;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  VEC[i].e_rd, VEC[i].e_hs, VEC[i].e_irq, VEC[i].e_dma);
        end

        // R10: reset in the middle of a forced stall with a pending packet
        idle_inputs();
        pkt_done = 1;
        @(negedge clk);
        pkt_done = 0; reg_wr = 1; reg_wdata = 4'h8;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
        @(negedge clk);
        check("R6 forced stall before reset", 6'h0D, STL, 0, 0);
        rst_n = 1'b0;
        #1;
        check("R10 reset clears stall", 6'h00, ACK, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 state after reset release", 6'h00, ACK, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule